// File: doc/BRIEF.md
# Fat-Tree Router Input-Port Routing Unit

This block is the input stage of one port of a router in a binary fat-tree network whose downward links are doubled, so an output picked by the port is never contended. The router's row and column are fixed at elaboration. On the first flit of a packet, the port takes the destination client address from the low bits of that flit. It decides which of its two outputs the packet uses and holds that decision. Every later flit of the packet is steered the same way until the flit that closes the packet has gone through. The port has no storage for flits. The stall signal of the chosen output is passed straight back to the sender.

One parameter picks the variant. An upward port sits on a link from below. It either keeps climbing on its own side (channel 0) or, when this router is the packet's summit, folds the packet onto the downward output of the opposite side (channel 1). A downward port sits on a link from above. It sends the packet to the left subtree (channel 0) or to the right subtree (channel 1). Clients are numbered so that a client address is twice its row-0 router column plus 0 for the left client or 1 for the right client.

Top module: `ft_route_port`

## Requirements
- R1: After reset no packet is open, no output is valid, and the held channel is 0. While idle, in_stall therefore mirrors out_stall[0].
- R2: In the upward variant, a header whose destination is not below this router goes to channel 0, which continues upward on the same side.
- R3: In the upward variant, the router is the summit when destination bits [N_ROWS-1:ROW+1] equal bits [N_ROWS-2:ROW] of the column with its low ROW bits cleared. The destination is in_data[N_ROWS-1:0] of the header. A summit header goes to channel 1, the folding output. In the top row every header is a summit.
- R4: In the downward variant, the header goes to the channel given by destination bit ROW: 0 selects left (channel 0) and 1 selects right (channel 1).
- R5: Flits that follow the header go to the header's channel whatever their data, until and including the flit with in_eop set.
- R6: A valid flit with in_sop low is discarded when no packet is open: no output valid and no change of state.
- R7: in_stall equals out_stall of the selected channel. The selected channel is the new decision when in_valid and in_sop are both high, and the held one otherwise. While in_stall is high no output is valid and the state does not move.
- R8: A flit with both in_sop and in_eop forms a complete packet and leaves the port idle.
- R9: A header arriving while a packet is open starts a new packet with a fresh decision.
- R10: A forwarded flit appears in the same cycle with in_data, in_sop and in_eop unchanged on out_data, out_sop and out_eop.
- R11: At most one bit of out_valid is set in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Incoming flit present |
| in_sop | input | 1 | Incoming flit is a header |
| in_eop | input | 1 | Incoming flit closes the packet |
| in_data | input | DATA_W | Incoming flit; header carries destination in low N_ROWS bits |
| in_stall | output | 1 | Backpressure to the sender |
| out_valid | output | 2 | Flit forwarded on channel 0 or 1 |
| out_sop | output | 1 | Forwarded header marker |
| out_eop | output | 1 | Forwarded end marker |
| out_data | output | DATA_W | Forwarded flit |
| out_stall | input | 2 | Backpressure from channel 0 and 1 |

## Verification
A new header can arrive while the previous packet is still open, so two things fall in the same cycle: the fresh routing decision and the choice of which output's stall gates the flit. The bench provokes this with back-to-back headers and with headers that arrive while only one channel is stalled. A reference model kept in the bench decides the outcome. The flit must be gated by the stall of the new channel, not the held one, and the new channel must be kept for the body that follows.

// File: rtl/ft_route_pkg.sv
package ft_route_pkg;
    typedef enum logic {
        CH_A = 1'b0,
        CH_B = 1'b1
    } chan_e;

    typedef struct packed {
        logic  open;
        chan_e route;
    } track_s;
endpackage

// File: rtl/ft_route_decide.sv
module ft_route_decide
    import ft_route_pkg::*;
#(
    parameter int N_ROWS = 4,
    parameter int ROW    = 1,
    parameter int COL    = 5,
    parameter bit IS_UP  = 1'b1
) (
    input  logic [N_ROWS-1:0] daddr,
    output chan_e             pick
);
    localparam int AW = N_ROWS;
    localparam logic [AW-1:0] LOW_MASK  = AW'((1 << ROW) - 1);
    localparam logic [AW-1:0] COL_BASE  = AW'(COL) & ~LOW_MASK;
    localparam logic [AW-1:0] REACH_LO  = COL_BASE << 1;
    localparam logic [AW-1:0] HI_MASK   = ~AW'((1 << (ROW + 1)) - 1);
    localparam logic [AW-1:0] DIR_MASK  = AW'(1 << ROW);

    generate
        if (IS_UP) begin : g_up
            logic summit;
            // summit: destination high bits match the subtree's first client
            assign summit = ((daddr & HI_MASK) == (REACH_LO & HI_MASK));
            assign pick   = summit ? CH_B : CH_A;
        end else begin : g_down
            assign pick = ((daddr & DIR_MASK) != '0) ? CH_B : CH_A;
        end
    endgenerate
endmodule

// File: rtl/ft_route_track.sv
module ft_route_track
    import ft_route_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  hdr,
    input  logic  accept,
    input  logic  eop,
    input  chan_e pick,
    output chan_e sel,
    output logic  open
);
    track_s st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (accept) begin
            if (hdr) begin
                st_d.route = pick;
            end
            st_d.open = !eop;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{open: 1'b0, route: CH_A};
        end else begin
            st_q <= st_d;
        end
    end

    assign sel  = hdr ? pick : st_q.route;
    assign open = st_q.open;
endmodule

// File: rtl/ft_route_steer.sv
module ft_route_steer
    import ft_route_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int N_CH   = 2
) (
    input  logic              in_valid,
    input  logic              in_sop,
    input  logic              in_eop,
    input  logic [DATA_W-1:0] in_data,
    input  logic              open,
    input  chan_e             sel,
    input  logic [N_CH-1:0]   out_stall,
    output logic              in_stall,
    output logic              accept,
    output logic [N_CH-1:0]   out_valid,
    output logic              out_sop,
    output logic              out_eop,
    output logic [DATA_W-1:0] out_data
);
    logic head;

    assign head     = in_valid && (in_sop || open);
    assign in_stall = out_stall[sel];
    assign accept   = head && !in_stall;

    generate
        for (genvar i = 0; i < N_CH; i++) begin : g_ch
            assign out_valid[i] = accept && (int'(sel) == i);
        end
    endgenerate

    assign out_sop  = in_sop;
    assign out_eop  = in_eop;
    assign out_data = in_data;
endmodule

// File: rtl/ft_route_port.sv
module ft_route_port
    import ft_route_pkg::*;
#(
    parameter int N_ROWS = 4,
    parameter int ROW    = 1,
    parameter int COL    = 5,
    parameter bit IS_UP  = 1'b1,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic              in_sop,
    input  logic              in_eop,
    input  logic [DATA_W-1:0] in_data,
    output logic              in_stall,
    output logic [1:0]        out_valid,
    output logic              out_sop,
    output logic              out_eop,
    output logic [DATA_W-1:0] out_data,
    input  logic [1:0]        out_stall
);
    chan_e pick, sel;
    logic  open, accept, hdr;

    assign hdr = in_valid && in_sop;

    ft_route_decide #(
        .N_ROWS(N_ROWS), .ROW(ROW), .COL(COL), .IS_UP(IS_UP)
    ) u_decide (
        .daddr(in_data[N_ROWS-1:0]),
        .pick (pick)
    );

    ft_route_track u_track (
        .clk   (clk),
        .rst_n (rst_n),
        .hdr   (hdr),
        .accept(accept),
        .eop   (in_eop),
        .pick  (pick),
        .sel   (sel),
        .open  (open)
    );

    ft_route_steer #(.DATA_W(DATA_W), .N_CH(2)) u_steer (
        .in_valid (in_valid),
        .in_sop   (in_sop),
        .in_eop   (in_eop),
        .in_data  (in_data),
        .open     (open),
        .sel      (sel),
        .out_stall(out_stall),
        .in_stall (in_stall),
        .accept   (accept),
        .out_valid(out_valid),
        .out_sop  (out_sop),
        .out_eop  (out_eop),
        .out_data (out_data)
    );
endmodule

// File: rtl/ft_route_port_chk.sv
module ft_route_port_chk #(
    parameter int N_ROWS = 4,
    parameter int ROW    = 1,
    parameter bit IS_UP  = 1'b1,
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic [DATA_W-1:0] in_data,
    input logic              in_stall,
    input logic [1:0]        out_valid,
    input logic              out_sop,
    input logic              out_eop,
    input logic [DATA_W-1:0] out_data,
    input logic [1:0]        out_stall
);
    assert_onehot_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(out_valid));

    assert_stall_blocks_R7: assert property (@(posedge clk) disable iff (!rst_n)
        in_stall |-> (out_valid == 2'b00));

    assert_chan_free_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid[0] |-> !out_stall[0]) and (out_valid[1] |-> !out_stall[1]));

    assert_passthru_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (|out_valid) |-> (in_valid && (out_data == in_data)));

    assert_body_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ((|out_valid) && !out_sop && $past((|out_valid) && !out_eop))
            |-> (out_valid == $past(out_valid)));

    generate
        if (!IS_UP) begin : g_dn
            assert_dir_bit_R4: assert property (@(posedge clk) disable iff (!rst_n)
                ((|out_valid) && out_sop) |-> (out_valid[1] == out_data[ROW]));
        end
    endgenerate
endmodule

bind ft_route_port ft_route_port_chk #(
    .N_ROWS(N_ROWS), .ROW(ROW), .IS_UP(IS_UP), .DATA_W(DATA_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_data  (in_data),
    .in_stall (in_stall),
    .out_valid(out_valid),
    .out_sop  (out_sop),
    .out_eop  (out_eop),
    .out_data (out_data),
    .out_stall(out_stall)
);

// File: tb/ft_route_port_tb.sv
module ft_route_port_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       v = 1'b0, s = 1'b0, e = 1'b0;
    logic [7:0] d = '0;
    logic [1:0] st = '0;

    logic       stl_u, stl_d, sop_u, sop_d, eop_u, eop_d;
    logic [1:0] ov_u, ov_d;
    logic [7:0] od_u, od_d;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    // model state: index 0 = upward port (ROW 1, COL 5), index 1 = downward port (ROW 2)
    logic act [2];
    logic rte [2];

    always #5 clk = ~clk;

    ft_route_port #(.N_ROWS(4), .ROW(1), .COL(5), .IS_UP(1'b1), .DATA_W(8)) u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(v), .in_sop(s), .in_eop(e), .in_data(d),
        .in_stall(stl_u), .out_valid(ov_u), .out_sop(sop_u), .out_eop(eop_u),
        .out_data(od_u), .out_stall(st)
    );

    ft_route_port #(.N_ROWS(4), .ROW(2), .COL(3), .IS_UP(1'b0), .DATA_W(8)) u_dut_dn (
        .clk(clk), .rst_n(rst_n), .in_valid(v), .in_sop(s), .in_eop(e), .in_data(d),
        .in_stall(stl_d), .out_valid(ov_d), .out_sop(sop_d), .out_eop(eop_d),
        .out_data(od_d), .out_stall(st)
    );

    // R3: column 5 at row 1 covers clients 8..11 -> fold; R2 otherwise
    function automatic logic dec(input int k, input logic [7:0] x);
        if (k == 0) return (x[3:0] >= 4'd8 && x[3:0] <= 4'd11);
        return x[2]; // R4
    endfunction

    task automatic chk(input string tag, input string what, input logic [7:0] act_v,
                       input logic [7:0] exp_v);
        n_checks++;
        if (act_v !== exp_v) begin
            n_fails++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act_v, exp_v);
        end
    endtask

    task automatic cyc(input logic iv, input logic is, input logic ie,
                       input logic [7:0] id, input logic [1:0] ist, input string tag);
        logic sel [2];
        logic acc [2];
        logic [1:0] eov [2];
        logic [1:0] aov [2];
        logic astl [2];
        logic [7:0] aod [2];
        logic asop [2], aeop [2];
        @(negedge clk);
        v = iv; s = is; e = ie; d = id; st = ist;
        #1;
        aov[0] = ov_u; aov[1] = ov_d; astl[0] = stl_u; astl[1] = stl_d;
        aod[0] = od_u; aod[1] = od_d; asop[0] = sop_u; asop[1] = sop_d;
        aeop[0] = eop_u; aeop[1] = eop_d;
        for (int k = 0; k < 2; k++) begin
            sel[k] = (iv && is) ? dec(k, id) : rte[k];
            acc[k] = iv && (is || act[k]) && !ist[sel[k]];
            eov[k] = acc[k] ? (sel[k] ? 2'b10 : 2'b01) : 2'b00;
            chk(tag, k == 0 ? "up out_valid" : "dn out_valid", {6'd0, aov[k]}, {6'd0, eov[k]});
            chk(tag, k == 0 ? "up in_stall R7" : "dn in_stall R7",
                {7'd0, astl[k]}, {7'd0, ist[sel[k]]});
            if (acc[k]) begin
                chk(tag, "data R10", aod[k], id);
                chk(tag, "sop/eop R10", {6'd0, asop[k], aeop[k]}, {6'd0, is, ie});
            end
        end
        @(posedge clk);
        for (int k = 0; k < 2; k++) begin
            if (acc[k]) begin
                if (is) rte[k] = sel[k];
                act[k] = !ie;
            end
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fails++;
            $display("FAIL R5 watchdog: actual hung expected finished");
            $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        for (int k = 0; k < 2; k++) begin
            act[k] = 1'b0;
            rte[k] = 1'b0;
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1: idle after reset, channel 0 stall mirrored
        cyc(0, 0, 0, 8'h00, 2'b00, "R1");
        cyc(0, 0, 0, 8'h00, 2'b01, "R1");
        cyc(0, 0, 0, 8'h00, 2'b10, "R1");
        // R6: stray body flits dropped
        cyc(1, 0, 0, 8'h09, 2'b00, "R6");
        cyc(1, 0, 1, 8'h0C, 2'b00, "R6");
        // R2 / R4 / R5: address 3 climbs / left; body data would point elsewhere
        cyc(1, 1, 0, 8'h03, 2'b00, "R2");
        cyc(1, 0, 0, 8'hFF, 2'b00, "R5");
        cyc(1, 0, 0, 8'h0C, 2'b00, "R5");
        cyc(1, 0, 1, 8'h08, 2'b00, "R5");
        cyc(1, 0, 0, 8'h08, 2'b00, "R6");
        // R3 boundaries 8 and 11 fold, 7 and 12 climb; R4 on bit 2
        cyc(1, 1, 1, 8'h08, 2'b00, "R3");
        cyc(1, 1, 1, 8'h0B, 2'b00, "R3");
        cyc(1, 1, 1, 8'h07, 2'b00, "R3");
        cyc(1, 1, 1, 8'h0C, 2'b00, "R4");
        cyc(1, 1, 1, 8'h04, 2'b00, "R4");
        // R8: single-flit packet leaves port idle
        cyc(1, 1, 1, 8'h09, 2'b00, "R8");
        cyc(1, 0, 0, 8'h00, 2'b00, "R8");
        // R7: stall of selected channel holds the flit; other channel's stall ignored
        cyc(1, 1, 0, 8'h0D, 2'b00, "R7");
        cyc(1, 0, 0, 8'h11, 2'b01, "R7");
        cyc(1, 0, 0, 8'h11, 2'b10, "R7");
        cyc(1, 0, 0, 8'h11, 2'b11, "R7");
        cyc(1, 0, 1, 8'h12, 2'b00, "R7");
        // R9: header inside an open packet redecides; stall judged on new channel
        cyc(1, 1, 0, 8'h03, 2'b00, "R9");
        cyc(1, 1, 0, 8'h0A, 2'b01, "R9");
        cyc(1, 1, 0, 8'h0A, 2'b10, "R9");
        cyc(1, 0, 0, 8'h00, 2'b00, "R9");
        cyc(1, 0, 1, 8'h00, 2'b00, "R9");
        // random traffic, R2 R3 R4 R5 R6 R7 R9 R10
        for (int i = 0; i < 4000; i++) begin
            logic rv, rs, re;
            logic [1:0] rst2;
            rv = ($urandom_range(99) < 75);
            rs = ($urandom_range(99) < 25);
            re = ($urandom_range(99) < 30);
            rst2 = {($urandom_range(99) < 15), ($urandom_range(99) < 15)};
            cyc(rv, rs, re, 8'($urandom), rst2, "R5 random");
        end
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    end
endmodule